// File: doc/BRIEF.md
# Start-up Bus Sequencer with Ready Stall

This block drives the bus of a small 8-bit processor front end from reset up to and including its first opcode fetch. Once reset is released it runs three dummy reads at the program counter and then three stack-page cycles. Next it reads a two-byte start vector, loads the program counter from it, and fetches the first opcode. The block drives the address bus, a read/write strobe (1 = read), an opcode-fetch flag and a stall flag. It takes read data from the bus and steps once for each machine-cycle enable.

The ready input acts as back-pressure on reads only. When ready is low at an enabled edge during a read cycle, that cycle does not complete and is repeated with the same address and strobe. A write cycle always completes whatever ready does, and any stall then starts at the next read. In the normal start-up mode the stack-page cycles are reads, so every cycle of the sequence can be held. A second mode, chosen when the sequence starts, turns the stack-page cycles into writes.

Top module: `rst_seq_top`

## Requirements
- R1: While rst_n is low, rw=1, sync=0, stall=0, fetch_done=0, addr=0x0000, sp=0x00 and pc=0x0000, and the sequence does not advance.
- R2: After reset is released, the first edge with cyc_en=1 starts the sequence. Completed cycles then present these addresses in order: 0x0000 three times (dummy reads at pc), 0x0100+sp three times, 0xFFFC, 0xFFFD, then pc for the opcode fetch.
- R3: sync is 1 exactly during the third dummy cycle and the opcode-fetch cycle, and stays 1 for as long as either cycle is stalled.
- R4: rd_data taken when the 0xFFFC cycle completes is the low byte of pc, and rd_data taken when the 0xFFFD cycle completes is the high byte. The opcode-fetch cycle then addresses that pc, and rd_data taken when it completes appears on opcode.
- R5: In a read cycle of the sequence with rdy=0, stall=1. An enabled edge then does not complete the cycle, and addr and rw keep their values.
- R6: An edge with cyc_en=0 changes no output except through reset.
- R7: stk_write is sampled at the edge that starts the sequence. If it was 1, the three stack-page cycles have rw=0 and complete even when rdy=0. A stall then begins at the next read cycle.
- R8: sp decrements by one only when a stack-page cycle completes, so it reads 0x00, 0xFF and 0xFE during those cycles and ends at 0xFD. Stalled repeats leave it unchanged.
- R9: After the opcode fetch completes, fetch_done=1, rw=1, sync=0 and stall=0, and addr, pc, sp and opcode stay fixed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cyc_en | input | 1 | machine-cycle enable |
| rdy | input | 1 | read ready; low holds a read cycle |
| stk_write | input | 1 | mode: stack-page cycles are writes |
| rd_data | input | 8 | read data from the bus |
| addr | output | 16 | address bus |
| rw | output | 1 | 1 = read, 0 = write |
| sync | output | 1 | opcode-fetch flag |
| stall | output | 1 | current cycle is being held by rdy |
| sp | output | 8 | stack pointer |
| pc | output | 16 | program counter |
| opcode | output | 8 | first fetched opcode |
| fetch_done | output | 1 | opcode fetch finished |

## Verification
The assertions assume that rdy, cyc_en, stk_write and rd_data change only away from the rising edge and stay steady until that edge. They also assume that reset is the only route back to the start of the sequence. The bench changes every input on the falling edge and lets rdy and cyc_en take arbitrary values across whole runs, including runs of several low cycles. It also releases and re-asserts reset in the middle of a sequence, so the reset-disabled properties are tested at restarts as well.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [3:0] {
    ST_RST  = 4'd0,
    ST_DMY0 = 4'd1,
    ST_DMY1 = 4'd2,
    ST_DMY2 = 4'd3,
    ST_STK0 = 4'd4,
    ST_STK1 = 4'd5,
    ST_STK2 = 4'd6,
    ST_VLO  = 4'd7,
    ST_VHI  = 4'd8,
    ST_OPF  = 4'd9,
    ST_IDLE = 4'd10
  } seq_st_e;
endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cyc_en,
  input  logic    rdy,
  input  logic    stk_write,
  output seq_st_e st,
  output logic    rd_cyc,
  output logic    hold,
  output logic    adv
);
  logic wr_mode;
  logic in_seq;
  logic in_stk;

  always_comb begin
    in_stk = (st == ST_STK0) || (st == ST_STK1) || (st == ST_STK2);
    in_seq = (st != ST_RST) && (st != ST_IDLE);
    rd_cyc = !(in_stk && wr_mode);
    hold   = in_seq && rd_cyc && !rdy;
    adv    = cyc_en && in_seq && !hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RST;
      wr_mode <= 1'b0;
    end else if (st == ST_RST) begin
      if (cyc_en) begin
        st      <= ST_DMY0;
        wr_mode <= stk_write;
      end
    end else if (adv) begin
      st <= seq_st_e'(st + 4'd1);
    end
  end
endmodule

// File: rtl/rst_seq_dpath.sv
module rst_seq_dpath
  import rst_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] STK_PAGE = 8'h01,
  parameter logic [DW-1:0] SP_INIT = 8'h00,
  parameter logic [2*DW-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_st_e         st,
  input  logic            adv,
  input  logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   sp,
  output logic [2*DW-1:0] pc,
  output logic [DW-1:0]   opcode
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] VEC_HI = VEC_ADDR + AW'(1);

  logic [DW-1:0] vec_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp     <= SP_INIT;
      pc     <= '0;
      vec_lo <= '0;
      opcode <= '0;
    end else if (adv) begin
      case (st)
        ST_STK0, ST_STK1, ST_STK2: sp <= sp - DW'(1);
        ST_VLO: vec_lo <= rd_data;
        ST_VHI: pc     <= {rd_data, vec_lo};
        ST_OPF: opcode <= rd_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_STK0, ST_STK1, ST_STK2: addr = {STK_PAGE, sp};
      ST_VLO:  addr = VEC_ADDR;
      ST_VHI:  addr = VEC_HI;
      default: addr = pc;
    endcase
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          rdy,
  input  logic          stk_write,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          rw,
  output logic          sync,
  output logic          stall,
  output logic [DW-1:0] sp,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] opcode,
  output logic          fetch_done
);
  seq_st_e st;
  logic    rd_cyc;
  logic    hold;
  logic    adv;

  rst_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .rdy(rdy),
    .stk_write(stk_write), .st(st), .rd_cyc(rd_cyc), .hold(hold), .adv(adv)
  );

  rst_seq_dpath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .adv(adv), .rd_data(rd_data),
    .addr(addr), .sp(sp), .pc(pc), .opcode(opcode)
  );

  assign rw         = rd_cyc;
  assign stall      = hold;
  assign sync       = (st == ST_DMY2) || (st == ST_OPF);
  assign fetch_done = (st == ST_IDLE);
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_en,
  input logic [AW-1:0] addr,
  input logic          rw,
  input logic          sync,
  input logic          stall,
  input logic [DW-1:0] sp,
  input logic [AW-1:0] pc,
  input logic          fetch_done
);
  always_comb begin
    if (!rst_n) begin
      a_rw_in_reset_r1: assert (rw && !stall && !sync);
    end
  end

  p_hold_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && stall) |=> ($stable(addr) && $stable(rw)));

  p_sync_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && stall && sync) |=> sync);

  p_write_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw) |-> !stall);

  p_sp_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && stall) |=> $stable(sp));

  p_no_en_no_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !fetch_done) |=> ($stable(addr) && $stable(sp) && $stable(pc)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (fetch_done && $stable(pc) && $stable(sp) && rw && !sync && !stall));
endmodule

bind rst_seq_top rst_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;
  logic        clk = 1'b0;
  logic        rst_n, cyc_en, rdy, stk_write;
  logic [7:0]  rd_data;
  logic [15:0] addr, pc;
  logic        rw, sync, stall, fetch_done;
  logic [7:0]  sp, opcode;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  // reference model state
  int        m_step;   // -1 reset, 0..8 sequence, 9 done
  logic [7:0]  m_sp, m_lo, m_op;
  logic [15:0] m_pc;
  bit        m_wmode;
  logic [15:0] prev_addr;
  bit        prev_en;

  always #10 clk = ~clk;

  rst_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .rdy(rdy), .stk_write(stk_write),
    .rd_data(rd_data), .addr(addr), .rw(rw), .sync(sync), .stall(stall),
    .sp(sp), .pc(pc), .opcode(opcode), .fetch_done(fetch_done)
  );

  function automatic bit exp_rw();
    return !(m_wmode && m_step >= 3 && m_step <= 5);
  endfunction

  function automatic logic [15:0] exp_addr();
    if (m_step >= 3 && m_step <= 5) return {8'h01, m_sp};
    if (m_step == 6) return 16'hFFFC;
    if (m_step == 7) return 16'hFFFD;
    return m_pc;
  endfunction

  function automatic bit exp_stall();
    return (m_step >= 0 && m_step <= 8) && exp_rw() && !rdy;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step=%0d actual=%h expected=%h", req, m_step, act, exp);
    end
  endtask

  task automatic model_reset();
    m_step = -1; m_sp = 8'h00; m_pc = 16'h0000; m_lo = 8'h00; m_op = 8'h00;
    m_wmode = 0;
  endtask

  task automatic compare();
    string t;
    t = (m_step == -1) ? "R1" : "R2";
    chk(t, addr, exp_addr());
    chk((m_step == -1) ? "R1" : "R7", {15'd0, rw}, {15'd0, exp_rw()});
    chk((m_step == -1) ? "R1" : "R3", {15'd0, sync}, {15'd0, (m_step == 2 || m_step == 8)});
    chk((m_step == -1) ? "R1" : "R5", {15'd0, stall}, {15'd0, exp_stall()});
    chk((m_step == -1) ? "R1" : "R8", {8'd0, sp}, {8'd0, m_sp});
    chk((m_step == -1) ? "R1" : "R4", pc, m_pc);
    chk("R4", {8'd0, opcode}, {8'd0, m_op});
    chk((m_step == -1) ? "R1" : "R9", {15'd0, fetch_done}, {15'd0, (m_step == 9)});
    if (rst_n && !prev_en && m_step != -1) chk("R6", addr, prev_addr);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      model_reset();
    end else if (cyc_en) begin
      if (m_step == -1) begin
        m_step = 0; m_wmode = stk_write;
      end else if (m_step >= 0 && m_step <= 8 && (rdy || !exp_rw())) begin
        if (m_step >= 3 && m_step <= 5) m_sp = m_sp - 8'd1;
        if (m_step == 6) m_lo = rd_data;
        if (m_step == 7) m_pc = {rd_data, m_lo};
        if (m_step == 8) m_op = rd_data;
        m_step++;
      end
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance model at rising edge
  task automatic tick(bit r, bit en, bit rd, bit sw);
    prev_addr = addr;
    rst_n = r; cyc_en = en; rdy = rd; stk_write = sw;
    rd_data = 8'($urandom_range(0, 255));
    if (!r) model_reset();
    #2;
    compare();
    prev_en = en;
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run(int n, int rdy_low_pct, int en_low_pct, bit sw);
    for (int i = 0; i < n; i++)
      tick(1'b1, ($urandom_range(0, 99) >= en_low_pct), ($urandom_range(0, 99) >= rdy_low_pct), sw);
  endtask

  task automatic do_reset(bit sw);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1, sw);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; cyc_en = 0; rdy = 1; stk_write = 0; rd_data = 0;
    prev_en = 1; prev_addr = 0;
    model_reset();
    @(negedge clk);
    // R1: reset state, R2/R4/R9 plain run
    do_reset(0);
    run(14, 0, 0, 0);
    // R5/R3/R8: random ready stalls
    do_reset(0);
    run(50, 45, 0, 0);
    // R7: write mode with random ready
    do_reset(1);
    run(50, 45, 0, 1);
    // R7 directed: ready low through the stack writes, stall lands on vector read
    do_reset(1);
    while (m_step < 3) tick(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, 1'b0, 1'b1);
    run(12, 0, 0, 1);
    // R6: random cycle enable
    do_reset(0);
    run(80, 30, 50, 0);
    // R1: reset in mid-sequence, then restart
    do_reset(0);
    run(5, 20, 0, 0);
    do_reset(1);
    run(40, 30, 20, 0);
    // R9: long idle after fetch
    run(20, 50, 0, 0);
    summary();
  end
endmodule